// File: doc/BRIEF.md
# Strobed packet serializer and deserializer

This block moves on-chip network packets across a narrow link. The transmit half takes one parallel packet on a slow packet clock. It sends that packet as a burst of sixteen narrow slices, timed by a network clock sixteen times faster. Beside the slices it drives a strobe that toggles once per slice and a frame-start line that marks the first slice.

The receive half uses no clock from the transmitter. It latches slices on both edges of the incoming strobe and rebuilds the packet from them. It then hands the packet to its own output clock through a small ring of holding registers with a Gray-coded write pointer. A parameter selects the packet format. The forward format is 80 bits: a 32-bit address, then 32-bit data, then a 16-bit header. The backward format is 48 bits: data then header.

The link wires of both halves come out as ports. One instance can therefore drive its own receiver in a loopback, or feed the receiver of another instance.

Top module: `strobe_link`

## Requirements
- R1: While rst_n is low, tx_ready is 1, rx_valid is 0, rx_err is 0, and lnk_strb_o, lnk_sof_o and lnk_dat_o are all 0.
- R2: With FWD=1 (80-bit packets), every packet accepted on the transmit port appears once on rx_pkt, bit for bit, in acceptance order. It is marked by rx_valid high for one rx clock cycle. This holds for back-to-back packets and for packets separated by idle gaps.
- R3: With FWD=0 (48-bit packets), the same delivery guarantee as R2 holds.
- R4: Each packet produces exactly NSLICE toggles of lnk_strb_o, so the strobe returns to its idle level after every packet. lnk_sof_o is high while the first slice is driven and low for every other slice.
- R5: Slices are ceil(W/NSLICE) bits wide: 5 bits for forward packets and 3 bits for backward packets. The most significant slice goes first. Fill bits below the packet's least significant bit are zero. The slice driven while lnk_sof_o is high is therefore the packet's top bits.
- R6: After a packet is accepted, tx_ready is 0 until its last slice has been sent. When no burst is in progress, lnk_strb_o holds its level, lnk_sof_o is 0 and lnk_dat_o is 0.
- R7: The receiver may see a frame start on a rising strobe edge before a packet is complete. It then discards the partial packet, restarts at slice 0, and delivers the new frame normally if that frame completes.
- R8: rx_err rises after a frame start interrupts a packet, and only then. It stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| clk_pkt | input | 1 | Transmit-side packet clock |
| tx_valid | input | 1 | A packet is offered on tx_pkt |
| tx_ready | output | 1 | Transmitter can accept a packet |
| tx_pkt | input | PKT_W | Packet to send (80 or 48 bits) |
| clk_net | input | 1 | Network clock, NSLICE times the packet clock |
| lnk_dat_o | output | SW | Outgoing data slice |
| lnk_strb_o | output | 1 | Outgoing strobe, one toggle per slice |
| lnk_sof_o | output | 1 | Outgoing frame start, high on the first slice |
| lnk_dat_i | input | SW | Incoming data slice |
| lnk_strb_i | input | 1 | Incoming strobe |
| lnk_sof_i | input | 1 | Incoming frame start |
| clk_rx | input | 1 | Receive-side output clock |
| rx_valid | output | 1 | One-cycle pulse: rx_pkt holds a packet |
| rx_pkt | output | PKT_W | Rebuilt packet |
| rx_err | output | 1 | Sticky interrupted-frame flag |

## Verification
The bench targets several ways the design can go wrong.

A receiver that latched on only one strobe edge, or that filed a slice under the wrong index, would return packets with swapped or stale slices. Long back-to-back runs in both formats compare every bit and would expose this.

A transmitter that raised tx_ready early would overwrite its holding register in the middle of a burst. An off-by-one slice count would leave the strobe at the wrong level. The bench would see the first as corrupted packets and the second as a wrong edge count.

A receiver that ignored a mid-frame start would emit a spliced packet or lose the packet that follows. An error flag that cleared itself would read 0 after later clean traffic. An injected broken frame followed by a valid one exercises both cases.

// File: rtl/strobe_link.sv
module strobe_link #(
  parameter int FWD    = 1,
  parameter int NSLICE = 16,
  parameter int DEPTH  = 4,
  localparam int PKT_W = (FWD != 0) ? 80 : 48,
  localparam int SW    = (PKT_W + NSLICE - 1) / NSLICE
) (
  input  logic             rst_n,
  input  logic             clk_pkt,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [PKT_W-1:0] tx_pkt,
  input  logic             clk_net,
  output logic [SW-1:0]    lnk_dat_o,
  output logic             lnk_strb_o,
  output logic             lnk_sof_o,
  input  logic [SW-1:0]    lnk_dat_i,
  input  logic             lnk_strb_i,
  input  logic             lnk_sof_i,
  input  logic             clk_rx,
  output logic             rx_valid,
  output logic [PKT_W-1:0] rx_pkt,
  output logic             rx_err
);
  localparam int PW   = SW * NSLICE;
  localparam int CW   = $clog2(NSLICE);
  localparam int HALF = NSLICE / 2;
  localparam int EW   = $clog2(HALF);
  localparam int HW   = EW + 1;
  localparam int IW   = $clog2(DEPTH);
  localparam int PTRW = IW + 1;

  function automatic logic [SW-1:0] pick(input logic [PW-1:0] v, input int k);
    return v[PW-1-k*SW -: SW];
  endfunction

  function automatic logic [PTRW-1:0] g2b(input logic [PTRW-1:0] g);
    logic [PTRW-1:0] b;
    b[PTRW-1] = g[PTRW-1];
    for (int i = PTRW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // transmit, packet clock side
  logic [PKT_W-1:0] hold;
  logic req_t, ack_t, ack_p1, ack_p2;

  assign tx_ready = (req_t == ack_p2);

  always_ff @(posedge clk_pkt or negedge rst_n)
    if (!rst_n) begin
      req_t  <= 1'b0;
      ack_p1 <= 1'b0;
      ack_p2 <= 1'b0;
    end else begin
      ack_p1 <= ack_t;
      ack_p2 <= ack_p1;
      if (tx_valid && tx_ready) req_t <= ~req_t;
    end

  always_ff @(posedge clk_pkt)
    if (tx_valid && tx_ready) hold <= tx_pkt;

  // transmit, network clock side
  logic [PW-1:0] pad;
  logic req_n1, req_n2, busy;
  logic [CW-1:0] cnt;

  always_comb begin
    pad = '0;
    pad[PW-1 -: PKT_W] = hold;
  end

  always_ff @(posedge clk_net or negedge rst_n)
    if (!rst_n) begin
      req_n1    <= 1'b0;
      req_n2    <= 1'b0;
      ack_t     <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
      lnk_dat_o <= '0;
      lnk_sof_o <= 1'b0;
    end else begin
      req_n1 <= req_t;
      req_n2 <= req_n1;
      if (busy) begin
        lnk_sof_o <= 1'b0;
        if (cnt == CW'(NSLICE - 1)) begin
          busy      <= 1'b0;
          ack_t     <= ~ack_t;
          lnk_dat_o <= '0;
        end else begin
          cnt       <= cnt + 1'b1;
          lnk_dat_o <= pick(pad, int'(cnt) + 1);
        end
      end else if (req_n2 != ack_t) begin
        busy      <= 1'b1;
        cnt       <= '0;
        lnk_dat_o <= pick(pad, 0);
        lnk_sof_o <= 1'b1;
      end
    end

  always_ff @(negedge clk_net or negedge rst_n)
    if (!rst_n) lnk_strb_o <= 1'b0;
    else if (busy) lnk_strb_o <= ~lnk_strb_o;

  // receive, strobe side
  logic [HW-1:0] rcnt;
  logic mid, err_q;
  logic [SW-1:0] ev [HALF];
  logic [SW-1:0] od [HALF];
  logic [PW-1:0] frame;
  logic [PKT_W-1:0] ring [DEPTH];
  logic [PTRW-1:0] wp, wg;

  assign mid = (rcnt != '0) && (rcnt != HW'(HALF));

  always_ff @(posedge lnk_strb_i or negedge rst_n)
    if (!rst_n) begin
      rcnt  <= '0;
      err_q <= 1'b0;
    end else if (lnk_sof_i) begin
      if (mid) err_q <= 1'b1;
      rcnt <= HW'(1);
    end else if (mid) begin
      rcnt <= rcnt + 1'b1;
    end

  always_ff @(posedge lnk_strb_i)
    if (lnk_sof_i) ev[0] <= lnk_dat_i;
    else if (mid) ev[EW'(rcnt)] <= lnk_dat_i;

  always_comb
    for (int k = 0; k < NSLICE; k++)
      if (k % 2 == 0)         frame[PW-1-k*SW -: SW] = ev[k/2];
      else if (k == NSLICE-1) frame[PW-1-k*SW -: SW] = lnk_dat_i;
      else                    frame[PW-1-k*SW -: SW] = od[k/2];

  always_ff @(negedge lnk_strb_i or negedge rst_n)
    if (!rst_n) begin
      wp <= '0;
      wg <= '0;
    end else if (rcnt == HW'(HALF)) begin
      wp <= wp + 1'b1;
      wg <= (wp + 1'b1) ^ ((wp + 1'b1) >> 1);
    end

  always_ff @(negedge lnk_strb_i) begin
    if (rcnt != '0) od[EW'(rcnt - 1'b1)] <= lnk_dat_i;
    if (rcnt == HW'(HALF)) ring[wp[IW-1:0]] <= frame[PW-1 -: PKT_W];
  end

  // receive, output clock side
  logic [PTRW-1:0] wg_s1, wg_s2, rp;
  logic err_s1;

  always_ff @(posedge clk_rx or negedge rst_n)
    if (!rst_n) begin
      wg_s1    <= '0;
      wg_s2    <= '0;
      rp       <= '0;
      err_s1   <= 1'b0;
      rx_err   <= 1'b0;
      rx_valid <= 1'b0;
      rx_pkt   <= '0;
    end else begin
      wg_s1  <= wg;
      wg_s2  <= wg_s1;
      err_s1 <= err_q;
      rx_err <= err_s1;
      if (g2b(wg_s2) != rp) begin
        rx_valid <= 1'b1;
        rx_pkt   <= ring[rp[IW-1:0]];
        rp       <= rp + 1'b1;
      end else begin
        rx_valid <= 1'b0;
      end
    end
endmodule

module strobe_link_chk (
  input logic rst_n,
  input logic clk_pkt,
  input logic clk_net,
  input logic clk_rx,
  input logic tx_valid,
  input logic tx_ready,
  input logic busy,
  input logic lnk_strb_o,
  input logic lnk_sof_o,
  input logic rx_err
);
  // R6
  ready_drop_chk: assert property (@(posedge clk_pkt) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R6
  idle_strobe_chk: assert property (@(posedge clk_net) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(lnk_strb_o));

  // R4
  sof_single_chk: assert property (@(posedge clk_net) disable iff (!rst_n)
    lnk_sof_o |=> !lnk_sof_o);

  // R8
  err_sticky_chk: assert property (@(posedge clk_rx) disable iff (!rst_n)
    rx_err |=> rx_err);
endmodule

bind strobe_link strobe_link_chk u_chk (
  .rst_n(rst_n), .clk_pkt(clk_pkt), .clk_net(clk_net), .clk_rx(clk_rx),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .busy(busy),
  .lnk_strb_o(lnk_strb_o), .lnk_sof_o(lnk_sof_o), .rx_err(rx_err)
);

// File: tb/strobe_link_test.sv
module strobe_link_test;
  logic clk_net = 0, clk_pkt = 0, clk_rx = 0, rst_n = 0;
  always #2  clk_net = ~clk_net;
  always #32 clk_pkt = ~clk_pkt;
  always #28 clk_rx  = ~clk_rx;

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // forward instance with an injection mux on its link inputs
  logic f_valid = 0, f_ready, f_strb_o, f_sof_o, f_rx_valid, f_rx_err;
  logic [79:0] f_pkt = '0, f_rx_pkt;
  logic [4:0] f_dat_o;
  logic inj = 0, inj_strb = 0, inj_sof = 0;
  logic [4:0] inj_dat = '0;
  wire [4:0] f_dat_i  = inj ? inj_dat  : f_dat_o;
  wire       f_strb_i = inj ? inj_strb : f_strb_o;
  wire       f_sof_i  = inj ? inj_sof  : f_sof_o;

  strobe_link #(.FWD(1)) uut (
    .rst_n(rst_n), .clk_pkt(clk_pkt), .tx_valid(f_valid), .tx_ready(f_ready), .tx_pkt(f_pkt),
    .clk_net(clk_net), .lnk_dat_o(f_dat_o), .lnk_strb_o(f_strb_o), .lnk_sof_o(f_sof_o),
    .lnk_dat_i(f_dat_i), .lnk_strb_i(f_strb_i), .lnk_sof_i(f_sof_i),
    .clk_rx(clk_rx), .rx_valid(f_rx_valid), .rx_pkt(f_rx_pkt), .rx_err(f_rx_err));

  logic b_valid = 0, b_ready, b_strb, b_sof, b_rx_valid, b_rx_err;
  logic [47:0] b_pkt = '0, b_rx_pkt;
  logic [2:0] b_dat;

  strobe_link #(.FWD(0)) uut_bwd (
    .rst_n(rst_n), .clk_pkt(clk_pkt), .tx_valid(b_valid), .tx_ready(b_ready), .tx_pkt(b_pkt),
    .clk_net(clk_net), .lnk_dat_o(b_dat), .lnk_strb_o(b_strb), .lnk_sof_o(b_sof),
    .lnk_dat_i(b_dat), .lnk_strb_i(b_strb), .lnk_sof_i(b_sof),
    .clk_rx(clk_rx), .rx_valid(b_rx_valid), .rx_pkt(b_rx_pkt), .rx_err(b_rx_err));

  logic [79:0] fq[$], fsent[$];
  logic [47:0] bq[$], bsent[$];

  function automatic logic [15:0] hdr();
    return {8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 2'b00};
  endfunction

  task automatic send_f(input logic [79:0] p);
    while (1) begin
      @(negedge clk_pkt);
      if (f_ready) break;
    end
    f_valid = 1; f_pkt = p;
    fq.push_back(p); fsent.push_back(p);
    @(negedge clk_pkt);
    f_valid = 0;
    chk(!f_ready, "R6 fwd ready low after accept", 80'(f_ready), 80'(0));
  endtask

  task automatic send_b(input logic [47:0] p);
    while (1) begin
      @(negedge clk_pkt);
      if (b_ready) break;
    end
    b_valid = 1; b_pkt = p;
    bq.push_back(p); bsent.push_back(p);
    @(negedge clk_pkt);
    b_valid = 0;
    chk(!b_ready, "R6 bwd ready low after accept", 80'(b_ready), 80'(0));
  endtask

  // scoreboard monitors
  always @(negedge clk_rx)
    if (rst_n && f_rx_valid) begin
      if (fq.size() == 0) chk(0, "R2 unexpected fwd packet", f_rx_pkt, '0);
      else begin
        logic [79:0] e;
        e = fq.pop_front();
        chk(f_rx_pkt === e, "R2 fwd packet", f_rx_pkt, e);
      end
    end

  always @(negedge clk_rx)
    if (rst_n && b_rx_valid) begin
      if (bq.size() == 0) chk(0, "R3 unexpected bwd packet", 80'(b_rx_pkt), '0);
      else begin
        logic [47:0] e;
        e = bq.pop_front();
        chk(b_rx_pkt === e, "R3 bwd packet", 80'(b_rx_pkt), 80'(e));
      end
    end

  // link-side monitors
  int f_edges = 0, f_sofs = 0, b_edges = 0, b_sofs = 0;
  logic f_prev = 0, b_prev = 0;
  always @(negedge clk_net) begin
    #1;
    if (rst_n) begin
      if (f_strb_o != f_prev) f_edges++;
      if (b_strb != b_prev) b_edges++;
      if (f_sof_o) begin
        if (f_sofs < fsent.size())
          chk(f_dat_o === fsent[f_sofs][79 -: 5], "R5 fwd first slice", 80'(f_dat_o), 80'(fsent[f_sofs][79 -: 5]));
        f_sofs++;
      end
      if (b_sof) begin
        if (b_sofs < bsent.size())
          chk(b_dat === bsent[b_sofs][47 -: 3], "R5 bwd first slice", 80'(b_dat), 80'(bsent[b_sofs][47 -: 3]));
        b_sofs++;
      end
    end
    f_prev = f_strb_o;
    b_prev = b_strb;
  end

  task automatic inj_slice(input logic [4:0] d, input logic s);
    inj_dat = d; inj_sof = s;
    #2 inj_strb = ~inj_strb;
    #2;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_net);
    failures++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", fq.size() + bq.size(), 0);
    summary();
  end

  initial begin
    #100;
    chk(f_ready === 1'b1, "R1 tx_ready in reset", 80'(f_ready), 80'(1));
    chk(f_rx_valid === 1'b0, "R1 rx_valid in reset", 80'(f_rx_valid), 80'(0));
    chk(f_rx_err === 1'b0, "R1 rx_err in reset", 80'(f_rx_err), 80'(0));
    chk({f_strb_o, f_sof_o, f_dat_o} === '0, "R1 link idle in reset", 80'({f_strb_o, f_sof_o, f_dat_o}), 80'(0));
    chk({b_ready, b_rx_valid, b_strb, b_sof} === 4'b1000, "R1 bwd reset", 80'({b_ready, b_rx_valid, b_strb, b_sof}), 80'(8));
    #100 rst_n = 1;

    fork
      begin
        for (int i = 0; i < 20; i++) send_f({32'($urandom), 32'($urandom), hdr()});
        for (int i = 0; i < 10; i++) begin
          repeat ($urandom % 5) @(negedge clk_pkt);
          send_f({32'($urandom), 32'($urandom), hdr()});
        end
      end
      begin
        for (int i = 0; i < 20; i++) send_b({32'($urandom), hdr()});
        for (int i = 0; i < 10; i++) begin
          repeat ($urandom % 5) @(negedge clk_pkt);
          send_b({32'($urandom), hdr()});
        end
      end
    join

    repeat (10) @(negedge clk_pkt);
    chk(f_rx_err === 1'b0, "R8 no error on clean traffic", 80'(f_rx_err), 80'(0));
    chk(fq.size() == 0, "R2 fwd queue drained", 80'(fq.size()), 80'(0));

    // R7: interrupted frame, then a complete one
    begin
      logic [79:0] p;
      p = {32'hA5A5_0F0F, 32'h1234_5678, 16'hC3A8};
      fq.push_back(p);
      inj_strb = 0;
      inj = 1;
      for (int k = 0; k < 6; k++) inj_slice(5'($urandom), k == 0);
      for (int k = 0; k < 16; k++) inj_slice(p[79 - k*5 -: 5], k == 0);
      inj_sof = 0;
      inj_dat = '0;
      #4 inj = 0;
    end
    repeat (10) @(negedge clk_rx);
    chk(fq.size() == 0, "R7 only the complete frame delivered", 80'(fq.size()), 80'(0));
    chk(f_rx_err === 1'b1, "R8 error set by interrupted frame", 80'(f_rx_err), 80'(1));

    for (int i = 0; i < 5; i++) send_f({32'($urandom), 32'($urandom), hdr()});
    repeat (40) @(negedge clk_rx);
    chk(f_rx_err === 1'b1, "R8 error stays set", 80'(f_rx_err), 80'(1));
    chk(fq.size() == 0, "R2 fwd all delivered", 80'(fq.size()), 80'(0));
    chk(bq.size() == 0, "R3 bwd all delivered", 80'(bq.size()), 80'(0));
    chk(f_edges == 16 * fsent.size(), "R4 fwd strobe toggles", 80'(f_edges), 80'(16 * fsent.size()));
    chk(b_edges == 16 * bsent.size(), "R4 bwd strobe toggles", 80'(b_edges), 80'(16 * bsent.size()));
    chk(f_sofs == fsent.size(), "R4 fwd one frame start per packet", 80'(f_sofs), 80'(fsent.size()));
    chk(b_sofs == bsent.size(), "R4 bwd one frame start per packet", 80'(b_sofs), 80'(bsent.size()));
    chk({f_strb_o, f_sof_o, f_dat_o} === '0, "R6 fwd link idle", 80'({f_strb_o, f_sof_o, f_dat_o}), 80'(0));
    chk({b_strb, b_sof, b_dat} === '0, "R6 bwd link idle", 80'({b_strb, b_sof, b_dat}), 80'(0));
    chk(f_ready && b_ready, "R6 ready back after bursts", 80'({f_ready, b_ready}), 80'(3));
    summary();
  end
endmodule